// File: doc/BRIEF.md
# Multi-Event Trigger Capture Buffer

This block records the sample stream of one digitizer channel into a sample memory that is cut into a selectable number of equal event slots. The slot being filled behaves as a ring: samples overwrite it continuously, so at any moment it holds the most recent history. When a trigger is accepted, the block keeps writing for a programmable tail of post-trigger samples. It then freezes the slot, records where the oldest sample sits and the timestamp taken at the trigger, and switches the very next sample into the following slot. No sample is lost at the switch.

Triggers come from an external pin, from a software strobe, or from a built-in threshold crossing detector. A separate read port drains frozen slots oldest-first, one word per handshake. Each event is read as its samples in time order, oldest first, followed by one timestamp word. Reading never stalls acquisition. When every slot is frozen and unread, the block raises a full flag and drops samples and triggers until the reader frees a slot.

The slot count and tail length are configuration inputs. They are only changed while reset is held.

Top module: `evt_capture_top`

## Requirements
- R1: Each event returned on the read port contains the last E samples that were accepted into its slot, up to and including the freezing sample, in arrival order. E is the event size.
- R2: After the trigger sample, exactly `cfg_post_len` further accepted samples are written, and the slot freezes on the last of them. `capture_busy` is high from the edge after the trigger until the freezing edge. With a tail of 0, the trigger sample itself freezes the slot.
- R3: The first accepted sample after a freeze is the first sample of the next slot, so events produced back to back are contiguous in the stream.
- R4: With `cfg_slot_log2` = k, the block has 2^k slots of E = DEPTH / 2^k samples each. `cfg_post_len` must lie in 0..E-1, and the pre-trigger part is E minus the tail.
- R5: Events are read in freeze order. Each event is E sample words (the sample zero-extended, `rd_is_ts` = 0) followed by one word holding the timestamp (`rd_is_ts` = 1). A word advances only on `rd_valid` && `rd_ready`, and it holds otherwise.
- R6: The timestamp of an event equals the number of clock edges seen with reset released before the edge that accepted its trigger. The counter is 31 bits wide and wraps at 2^31.
- R7: A trigger counts only on a cycle with `smp_valid` high. It is raised by `trig_ext`, by `trig_sw`, or, when `cfg_self_en` is set, by a sample above `cfg_thresh` whose previous valid sample was at or below it. The first sample after reset never self-triggers.
- R8: Triggers that arrive while a post-trigger tail is being written are ignored.
- R9: `mem_full` is high exactly when all slots are frozen and unread. While it is high, samples and triggers have no effect. After a slot is released, writing resumes at position 0 of that slot.
- R10: `occupancy` counts frozen, unread slots. It rises by one on each freeze and falls by one when the timestamp word of an event is taken.
- R11: During and right after reset, `occupancy` is 0 and `mem_full`, `capture_busy` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset; also clears the timestamp counter |
| cfg_slot_log2 | input | SL_W | Log2 of the slot count |
| cfg_post_len | input | ADDR_W | Post-trigger tail length in samples |
| cfg_thresh | input | DATA_W | Self-trigger threshold |
| cfg_self_en | input | 1 | Enables the threshold self-trigger |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Sample value |
| trig_ext | input | 1 | External trigger request |
| trig_sw | input | 1 | Software trigger request |
| rd_ready | input | 1 | Reader accepts the current word |
| rd_valid | output | 1 | A frozen event word is presented |
| rd_data | output | TS_W | Sample (zero-extended) or timestamp word |
| rd_is_ts | output | 1 | Current word is the event timestamp |
| occupancy | output | CNT_W | Number of frozen, unread slots |
| mem_full | output | 1 | All slots frozen and unread |
| capture_busy | output | 1 | Post-trigger tail in progress |

## Verification
A sample or trigger presented before an edge shows its effect on `occupancy`, `mem_full` and `capture_busy` after that same edge. The bench drives on the falling edge, updates its model right after the rising edge, and compares the flags at the next falling edge. Read words are combinational from the slot tables and the memory, so each word is compared at the falling edge before the handshake edge it belongs to. The edge that takes an event's timestamp word lowers `occupancy` by one. Timestamps are predicted from a bench count of edges taken after reset release, read just before the trigger edge.

// File: rtl/evt_cap_pkg.sv
// Shared definitions for the multi-event capture buffer.
package evt_cap_pkg;
    // Width of the trigger timestamp counter.
    localparam int TS_W = 31;

    // Phase of the slot currently being written.
    typedef enum logic {
        PH_FILL = 1'b0,   // ring filling, waiting for a trigger
        PH_POST = 1'b1    // writing the post-trigger tail
    } wr_phase_e;
endpackage

// File: rtl/evt_ts_counter.sv
// Free-running timestamp counter.
// Advances once per clock and wraps silently at its width.
// Assumes the clock period is the timestamp unit.
module evt_ts_counter #(
    parameter int TS_W = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts_now
);
    // Count clock edges since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_now <= '0;
        else        ts_now <= ts_now + 1'b1;
    end
endmodule

// File: rtl/evt_trig_detect.sv
// Trigger combiner: external, software and rising threshold crossing.
// A trigger is reported only alongside a valid sample. The previous
// sample is reset to all ones, so the first sample cannot cross.
module evt_trig_detect #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              trig_ext,
    input  logic              trig_sw,
    input  logic              self_en,
    input  logic [DATA_W-1:0] thresh,
    output logic              trig_hit
);
    logic [DATA_W-1:0] prev_q;
    logic              crossing;

    // Rising crossing: previous at or below threshold, current above.
    always_comb crossing = self_en && (prev_q <= thresh) && (smp_data > thresh);

    // Any source counts, gated by the sample strobe.
    always_comb trig_hit = smp_valid && (trig_ext || trig_sw || crossing);

    // Remember the last valid sample for crossing detection.
    always_ff @(posedge clk) begin
        if (!rst_n)         prev_q <= '1;
        else if (smp_valid) prev_q <= smp_data;
    end
endmodule

// File: rtl/evt_sample_mem.sv
// Sample store with one synchronous write port and one asynchronous
// read port. Reads and writes never target the same slot.
module evt_sample_mem #(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Write the accepted sample.
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    // Present the addressed word to the reader.
    always_comb rd_data = store[rd_addr];
endmodule

// File: rtl/evt_write_ctrl.sv
// Write side: ring addressing within the current slot, the
// post-trigger tail, the freeze hand-off and the occupancy count.
// Assumes the configuration is static outside reset and that
// cfg_post_len is below the event size.
module evt_write_ctrl
    import evt_cap_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int MAX_SL = 3,
    parameter int SL_W   = 2,
    parameter int CNT_W  = 4,
    parameter int SLOT_W = 3,
    parameter int TSW    = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SL_W-1:0]   cfg_slot_log2,
    input  logic [ADDR_W-1:0] cfg_post_len,
    input  logic              smp_valid,
    input  logic              trig_hit,
    input  logic [TSW-1:0]    ts_now,
    input  logic              release_slot,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              busy,
    output logic [CNT_W-1:0]  occupancy,
    output logic              mem_full,
    output logic              frz_valid,
    output logic [SLOT_W-1:0] frz_slot,
    output logic [ADDR_W-1:0] frz_start,
    output logic [TSW-1:0]    frz_ts
);
    localparam int SH_W = $clog2(ADDR_W + 1);

    wr_phase_e         phase_q;
    logic [SLOT_W-1:0] slot_q;
    logic [ADDR_W-1:0] pos_q;
    logic [ADDR_W-1:0] rem_q;
    logic [TSW-1:0]    trig_ts_q;

    logic [ADDR_W-1:0] pos_mask;
    logic [SLOT_W-1:0] slot_mask;
    logic [CNT_W-1:0]  nslots;
    logic [SH_W-1:0]   pos_bits;
    logic              accept;
    logic              take_trig;

    // Derive slot geometry from the configuration.
    always_comb begin
        pos_mask  = {ADDR_W{1'b1}} >> cfg_slot_log2;
        nslots    = CNT_W'(1) << cfg_slot_log2;
        slot_mask = SLOT_W'(nslots - 1'b1);
        pos_bits  = SH_W'(ADDR_W) - SH_W'(cfg_slot_log2);
    end

    // Accept, trigger and freeze decisions for this cycle.
    always_comb begin
        mem_full  = (occupancy == nslots);
        accept    = smp_valid && !mem_full;
        take_trig = accept && (phase_q == PH_FILL) && trig_hit;
        frz_valid = (take_trig && (cfg_post_len == '0)) ||
                    (accept && (phase_q == PH_POST) && (rem_q == ADDR_W'(1)));
        busy      = (phase_q == PH_POST);
    end

    // Memory write port and freeze record.
    always_comb begin
        wr_en     = accept;
        wr_addr   = (ADDR_W'(slot_q) << pos_bits) | pos_q;
        frz_slot  = slot_q;
        frz_start = (pos_q + 1'b1) & pos_mask;
        frz_ts    = (phase_q == PH_POST) ? trig_ts_q : ts_now;
    end

    // Position, slot and phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_FILL;
            slot_q    <= '0;
            pos_q     <= '0;
            rem_q     <= '0;
            trig_ts_q <= '0;
        end else if (accept) begin
            if (frz_valid) begin
                phase_q <= PH_FILL;
                slot_q  <= (slot_q + 1'b1) & slot_mask;
                pos_q   <= '0;
            end else begin
                pos_q <= (pos_q + 1'b1) & pos_mask;
                if (take_trig) begin
                    phase_q   <= PH_POST;
                    rem_q     <= cfg_post_len;
                    trig_ts_q <= ts_now;
                end else if (phase_q == PH_POST) begin
                    rem_q <= rem_q - 1'b1;
                end
            end
        end
    end

    // Frozen-unread slot count.
    always_ff @(posedge clk) begin
        if (!rst_n) occupancy <= '0;
        else        occupancy <= occupancy + CNT_W'(frz_valid) - CNT_W'(release_slot);
    end
endmodule

// File: rtl/evt_read_ctrl.sv
// Read side: per-slot start offset and timestamp tables, and the
// sequencing of sample words then timestamp word for the oldest
// frozen slot. Assumes the configuration is static outside reset.
module evt_read_ctrl #(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 8,
    parameter int SL_W   = 2,
    parameter int CNT_W  = 4,
    parameter int SLOT_W = 3,
    parameter int TSW    = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SL_W-1:0]   cfg_slot_log2,
    input  logic [CNT_W-1:0]  occupancy,
    input  logic              frz_valid,
    input  logic [SLOT_W-1:0] frz_slot,
    input  logic [ADDR_W-1:0] frz_start,
    input  logic [TSW-1:0]    frz_ts,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              rd_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              rd_valid,
    output logic [TSW-1:0]    rd_data,
    output logic              rd_is_ts,
    output logic              release_slot
);
    localparam int NSLOT = 1 << SLOT_W;
    localparam int SH_W  = $clog2(ADDR_W + 1);

    logic [ADDR_W-1:0] start_tab [NSLOT];
    logic [TSW-1:0]    ts_tab    [NSLOT];
    logic [SLOT_W-1:0] slot_q;
    logic [ADDR_W:0]   idx_q;

    logic [ADDR_W-1:0] pos_mask;
    logic [ADDR_W:0]   ev_size;
    logic [SLOT_W-1:0] slot_mask;
    logic [SH_W-1:0]   pos_bits;
    logic [ADDR_W-1:0] offset;
    logic              take;

    // One table entry per slot, written when that slot freezes.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // Capture the freeze record of slot s.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_tab[s] <= '0;
                ts_tab[s]    <= '0;
            end else if (frz_valid && (frz_slot == SLOT_W'(s))) begin
                start_tab[s] <= frz_start;
                ts_tab[s]    <= frz_ts;
            end
        end
    end

    // Slot geometry from the configuration.
    always_comb begin
        pos_mask  = {ADDR_W{1'b1}} >> cfg_slot_log2;
        ev_size   = {1'b0, pos_mask} + 1'b1;
        slot_mask = SLOT_W'((CNT_W'(1) << cfg_slot_log2) - 1'b1);
        pos_bits  = SH_W'(ADDR_W) - SH_W'(cfg_slot_log2);
    end

    // Address the oldest sample first and build the output word.
    always_comb begin
        offset       = (start_tab[slot_q] + idx_q[ADDR_W-1:0]) & pos_mask;
        mem_addr     = (ADDR_W'(slot_q) << pos_bits) | offset;
        rd_valid     = (occupancy != '0);
        rd_is_ts     = (idx_q == ev_size);
        rd_data      = rd_is_ts ? ts_tab[slot_q] : TSW'(mem_data);
        take         = rd_valid && rd_ready;
        release_slot = take && rd_is_ts;
    end

    // Step through the words of an event, then on to the next slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            idx_q  <= '0;
        end else if (take) begin
            if (rd_is_ts) begin
                idx_q  <= '0;
                slot_q <= (slot_q + 1'b1) & slot_mask;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/evt_capture_top.sv
// Multi-event capture buffer for one channel.
// Ties together trigger detection, the timestamp counter, the write
// and read controllers, and the sample memory.
// Assumes MAX_SL <= ADDR_W, DATA_W <= TS_W, and configuration
// changes only while rst_n is low.
module evt_capture_top
    import evt_cap_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 8,
    parameter int MAX_SL = 3,
    parameter int SL_W   = $clog2(MAX_SL + 1),
    parameter int CNT_W  = MAX_SL + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SL_W-1:0]   cfg_slot_log2,
    input  logic [ADDR_W-1:0] cfg_post_len,
    input  logic [DATA_W-1:0] cfg_thresh,
    input  logic              cfg_self_en,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              trig_ext,
    input  logic              trig_sw,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [TS_W-1:0]   rd_data,
    output logic              rd_is_ts,
    output logic [CNT_W-1:0]  occupancy,
    output logic              mem_full,
    output logic              capture_busy
);
    localparam int SLOT_W = (MAX_SL > 0) ? MAX_SL : 1;

    logic              trig_hit;
    logic [TS_W-1:0]   ts_now;
    logic              release_slot;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [DATA_W-1:0] mem_rd_data;
    logic              frz_valid;
    logic [SLOT_W-1:0] frz_slot;
    logic [ADDR_W-1:0] frz_start;
    logic [TS_W-1:0]   frz_ts;

    evt_trig_detect #(.DATA_W(DATA_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .trig_ext(trig_ext), .trig_sw(trig_sw), .self_en(cfg_self_en),
        .thresh(cfg_thresh), .trig_hit(trig_hit)
    );

    evt_ts_counter #(.TS_W(TS_W)) u_ts (
        .clk(clk), .rst_n(rst_n), .ts_now(ts_now)
    );

    evt_write_ctrl #(
        .ADDR_W(ADDR_W), .MAX_SL(MAX_SL), .SL_W(SL_W), .CNT_W(CNT_W),
        .SLOT_W(SLOT_W), .TSW(TS_W)
    ) u_wr (
        .clk(clk), .rst_n(rst_n), .cfg_slot_log2(cfg_slot_log2),
        .cfg_post_len(cfg_post_len), .smp_valid(smp_valid), .trig_hit(trig_hit),
        .ts_now(ts_now), .release_slot(release_slot), .wr_en(wr_en),
        .wr_addr(wr_addr), .busy(capture_busy), .occupancy(occupancy),
        .mem_full(mem_full), .frz_valid(frz_valid), .frz_slot(frz_slot),
        .frz_start(frz_start), .frz_ts(frz_ts)
    );

    evt_sample_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(smp_data),
        .rd_addr(mem_rd_addr), .rd_data(mem_rd_data)
    );

    evt_read_ctrl #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SL_W(SL_W), .CNT_W(CNT_W),
        .SLOT_W(SLOT_W), .TSW(TS_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .cfg_slot_log2(cfg_slot_log2),
        .occupancy(occupancy), .frz_valid(frz_valid), .frz_slot(frz_slot),
        .frz_start(frz_start), .frz_ts(frz_ts), .mem_data(mem_rd_data),
        .rd_ready(rd_ready), .mem_addr(mem_rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_is_ts(rd_is_ts), .release_slot(release_slot)
    );
endmodule

// File: rtl/evt_capture_checker.sv
// Temporal properties of the capture buffer, bound to the top module.
module evt_capture_checker #(
    parameter int SL_W  = 2,
    parameter int CNT_W = 4,
    parameter int TSW   = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SL_W-1:0]  cfg_slot_log2,
    input logic [CNT_W-1:0] occupancy,
    input logic             mem_full,
    input logic             capture_busy,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic             rd_is_ts,
    input logic [TSW-1:0]   rd_data,
    input logic [TSW-1:0]   ts_now
);
    logic [CNT_W-1:0] nslots;
    logic             rel;

    always_comb begin
        nslots = CNT_W'(1) << cfg_slot_log2;
        rel    = rd_valid && rd_ready && rd_is_ts;
    end

    p_occ_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= nslots);

    p_occ_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (occupancy == $past(occupancy)) ||
                         (occupancy == $past(occupancy) + 1'b1) ||
                         (occupancy == $past(occupancy) - 1'b1));

    p_full_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_full |-> !capture_busy);

    p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_full && !rel) |=> (occupancy == $past(occupancy)));

    p_freeze_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(capture_busy) && !$past(rel)) |->
            (occupancy == $past(occupancy) + 1'b1));

    p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_is_ts)));

    p_ts_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ts_now == $past(ts_now) + 1'b1));
endmodule

bind evt_capture_top evt_capture_checker #(
    .SL_W(SL_W), .CNT_W(CNT_W), .TSW(evt_cap_pkg::TS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_slot_log2(cfg_slot_log2),
    .occupancy(occupancy), .mem_full(mem_full), .capture_busy(capture_busy),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_is_ts(rd_is_ts),
    .rd_data(rd_data), .ts_now(ts_now)
);

// File: tb/tb_evt_capture_top.sv
module tb_evt_capture_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 12;
    localparam int ADDR_W = 8;
    localparam int MAX_SL = 3;
    localparam int SL_W   = 2;
    localparam int CNT_W  = 4;
    localparam int TS_W   = 31;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [SL_W-1:0]   cfg_slot_log2 = '0;
    logic [ADDR_W-1:0] cfg_post_len = '0;
    logic [DATA_W-1:0] cfg_thresh = '0;
    logic              cfg_self_en = 1'b0;
    logic              smp_valid = 1'b0;
    logic [DATA_W-1:0] smp_data = '0;
    logic              trig_ext = 1'b0;
    logic              trig_sw = 1'b0;
    logic              rd_ready = 1'b0;
    logic              rd_valid;
    logic [TS_W-1:0]   rd_data;
    logic              rd_is_ts;
    logic [CNT_W-1:0]  occupancy;
    logic              mem_full;
    logic              capture_busy;

    evt_capture_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_SL(MAX_SL)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_slot_log2(cfg_slot_log2),
        .cfg_post_len(cfg_post_len), .cfg_thresh(cfg_thresh),
        .cfg_self_en(cfg_self_en), .smp_valid(smp_valid), .smp_data(smp_data),
        .trig_ext(trig_ext), .trig_sw(trig_sw), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_is_ts(rd_is_ts),
        .occupancy(occupancy), .mem_full(mem_full), .capture_busy(capture_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    // Reference edge count since reset release (timestamp model).
    logic [TS_W-1:0] edges = '0;
    always @(posedge clk) begin
        if (!rst_n) edges <= '0;
        else        edges <= edges + 1'b1;
    end

    // Bench model state.
    int     stream[$];
    int     ev_f[$];
    longint ev_ts[$];
    int     slot_start, m_rem, m_occ, m_prev;
    bit     m_busy;
    longint m_tsp;
    int     sl, npost, nsl, evsz, th;
    bit     self_m;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_flags();
        chk(occupancy == CNT_W'(m_occ), "R10", "occupancy", occupancy, m_occ);
        chk(mem_full == (m_occ == nsl), "R9", "mem_full", mem_full, m_occ == nsl);
        chk(capture_busy == m_busy, "R2", "capture_busy", capture_busy, m_busy);
    endtask

    task automatic do_reset(input int s, input int n, input int t, input bit se);
        @(negedge clk);
        rst_n = 1'b0;
        sl = s; npost = n; th = t; self_m = se;
        nsl = 1 << s; evsz = DEPTH >> s;
        cfg_slot_log2 = SL_W'(s); cfg_post_len = ADDR_W'(n);
        cfg_thresh = DATA_W'(t); cfg_self_en = se;
        smp_valid = 0; trig_ext = 0; trig_sw = 0; rd_ready = 0;
        repeat (3) @(negedge clk);
        stream.delete(); ev_f.delete(); ev_ts.delete();
        slot_start = 0; m_rem = 0; m_occ = 0; m_busy = 0; m_tsp = 0;
        m_prev = (1 << DATA_W) - 1;
        rst_n = 1'b1;
        chk(occupancy == 0, "R11", "reset occupancy", occupancy, 0);
        chk(!mem_full, "R11", "reset mem_full", mem_full, 0);
        chk(!capture_busy, "R11", "reset busy", capture_busy, 0);
        chk(!rd_valid, "R11", "reset rd_valid", rd_valid, 0);
    endtask

    // One sample cycle: drive at negedge, model after posedge.
    task automatic cycle(input bit v, input int d, input bit ext, input bit sw);
        longint ts_at;
        bit hit, take, done;
        check_flags();
        smp_valid = v; smp_data = DATA_W'(d); trig_ext = ext; trig_sw = sw;
        ts_at = longint'(edges);
        @(posedge clk);
        if (v) begin
            hit = ext || sw || (self_m && m_prev <= th && d > th);
            m_prev = d;
            if (m_occ < nsl) begin
                stream.push_back(d);
                take = !m_busy && hit;
                done = (take && npost == 0) || (m_busy && m_rem == 1);
                if (done) begin
                    ev_f.push_back(stream.size() - 1);
                    ev_ts.push_back(take ? ts_at : m_tsp);
                    m_busy = 0; m_occ++; slot_start = stream.size();
                end else if (take) begin
                    m_busy = 1; m_rem = npost; m_tsp = ts_at;
                end else if (m_busy) begin
                    m_rem--;
                end
            end
        end
        @(negedge clk);
        smp_valid = 0; trig_ext = 0; trig_sw = 0;
    endtask

    function automatic bit trig_ok();
        return m_busy || (m_occ == nsl) ||
               ((stream.size() - slot_start + 1) >= (evsz - npost));
    endfunction

    task automatic rand_cycle();
        bit v, e, s;
        int r;
        v = ($urandom % 10) != 0;
        e = 0; s = 0;
        if (trig_ok() || !v) begin
            r = $urandom % 16;
            e = (r == 0); s = (r == 1);
        end
        cycle(v, $urandom % (1 << DATA_W), e, s);
    endtask

    task automatic acquire(input int want, input int extra);
        while (m_occ < want) rand_cycle();
        repeat (extra) rand_cycle();
    endtask

    // Read out every modelled event and compare word by word.
    task automatic drain();
        int f;
        longint t, exp;
        while (ev_f.size() > 0) begin
            f = ev_f.pop_front();
            t = ev_ts.pop_front();
            for (int k = 0; k <= evsz; k++) begin
                chk(rd_valid, "R5", "rd_valid during event", rd_valid, 1);
                if (k < evsz) begin
                    exp = stream[f - evsz + 1 + k];
                    if (k == 0) chk(rd_data == TS_W'(exp), "R3", "first sample", rd_data, exp);
                    else        chk(rd_data == TS_W'(exp), "R1", "sample", rd_data, exp);
                    chk(!rd_is_ts, "R5", "sample flagged as timestamp", rd_is_ts, 0);
                end else begin
                    chk(rd_is_ts, "R4", "timestamp word after event size", rd_is_ts, 1);
                    chk(rd_data == TS_W'(t), "R6", "timestamp", rd_data, t);
                end
                rd_ready = 1;
                @(posedge clk);
                if (k == evsz) m_occ--;
                @(negedge clk);
                rd_ready = 0;
            end
            chk(occupancy == CNT_W'(m_occ), "R10", "occupancy after release", occupancy, m_occ);
        end
        chk(!rd_valid, "R5", "rd_valid after drain", rd_valid, 0);
        check_flags();
    endtask

    task automatic scenario(input int s, input int n);
        do_reset(s, n, 0, 0);
        acquire(1 << s, 40);
        drain();
        acquire((1 << s) > 1 ? 2 : 1, 0);
        drain();
    endtask

    initial begin
        void'($urandom(32'h5EED_0017));
        scenario(0, 10);
        scenario(2, 0);
        scenario(3, 31);
        scenario(1, 64);

        // Directed: self-trigger, first sample, trigger during tail.
        do_reset(2, 5, 100, 1);
        cycle(1, 200, 0, 0);
        chk(!capture_busy, "R7", "first sample must not self-trigger", capture_busy, 0);
        for (int i = 0; i < 70; i++) cycle(1, $urandom % 101, 0, 0);
        chk(!capture_busy, "R7", "no crossing below threshold", capture_busy, 0);
        cycle(0, 0, 1, 1);
        chk(!capture_busy, "R7", "trigger without valid sample", capture_busy, 0);
        cycle(1, 150, 0, 0);
        chk(capture_busy, "R7", "rising crossing triggers", capture_busy, 1);
        cycle(1, 20, 0, 0);
        cycle(1, 30, 1, 1);
        cycle(1, 40, 0, 0);
        cycle(1, 50, 0, 0);
        cycle(1, 60, 0, 0);
        chk(occupancy == 1, "R8", "trigger in tail ignored", occupancy, 1);
        chk(!capture_busy, "R2", "frozen after tail", capture_busy, 0);
        drain();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R11 watchdog expired: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule